// File: doc/BRIEF.md
# Scatter Descriptor Table Builder

The block turns one block-transfer request into a list of 64-bit scatter descriptors for a data-moving engine that runs later. A request carries a byte count and the physical start address of the buffer. The builder walks through the request, cutting it into chunks that never exceed the per-descriptor length cap of 65532 bytes. For each chunk it emits one descriptor on a plain RAM write port: the first at table index 0, the next at index 1, and so on. Each descriptor carries the chunk address, the chunk length and the attribute bits that mark it as a valid data-transfer entry. Only the chunk that finishes the request carries the end-of-list flag.

The request side uses a valid/ready handshake, and the builder accepts one request at a time. Two kinds of request produce no descriptors at all. A request larger than the table can cover (1024 descriptors of 65532 bytes each) is refused with an error. A request of zero bytes completes cleanly with no entries. In every case the builder reports completion with a one-cycle done pulse and keeps the number of entries written on an output until the next completion. The table base address is a fixed output, so the consumer knows where the list starts.

Top module: `sgd_table_builder`

## Requirements
- R1: After reset, `req_ready` is 1, and `wr_en`, `done`, `err` and `entry_count` are all 0.
- R2: Every descriptor written has the following bits. Bit 0 (valid) is 1. Bit 2 (interrupt) is 0. Bit 4 is 0 and bit 5 is 1, which encodes the data-transfer action. Bit 3 and bits 15..6 are 0.
- R3: Descriptor k carries the chunk address in bits 63..32, equal to the request base plus the bytes covered by descriptors 0..k-1. It carries the chunk length in bits 31..16, equal to the smaller of the bytes still uncovered and 65532.
- R4: For an accepted request needing N descriptors, writes go to indices 0, 1, ..., N-1 in that order. There is one write per clock on N consecutive cycles, starting with the cycle after acceptance.
- R5: Bit 1 (end of list) is 1 on descriptor N-1 and 0 on every other descriptor.
- R6: A request of more than 1024 × 65532 = 67104768 bytes writes nothing. Its done pulse comes with `err` = 1, and `entry_count` becomes 0. A request of exactly 67104768 bytes is accepted and produces 1024 descriptors.
- R7: A zero-byte request writes nothing. Its done pulse comes with `err` = 0, and `entry_count` becomes 0.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last write, or the cycle after acceptance when nothing is written. In that cycle `entry_count` equals the number of descriptors written, and it holds that value until the next done.
- R9: `req_ready` is 0 from the cycle after acceptance until `done` is high. A `req_valid` held high, with changing fields, while the builder is busy starts no further request.
- R10: `tbl_base` always equals the `TBL_BASE` parameter (default 0x00004000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Builder idle and able to take a request |
| req_bytes | input | SIZE_W (32) | Request size in bytes |
| req_base | input | 32 | Physical start address of the buffer |
| wr_en | output | 1 | Descriptor RAM write strobe |
| wr_idx | output | IDX_W (10) | Table index being written |
| wr_data | output | 64 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused as oversize, valid with `done` |
| entry_count | output | IDX_W+1 (11) | Descriptors written by the last request |
| tbl_base | output | 32 | Address of table index 0 |

## Verification
The assertions assume that the descriptor RAM takes a write on every cycle, with no back-pressure. They also assume that reset is asserted from time zero. The address-continuity property relies on the next chunk address being the previous address plus the previous length, modulo 2^32. That holds as long as a buffer does not wrap the 32-bit address space, and every base address the stimulus uses leaves room for its request. The stimulus keeps request fields stable up to the acceptance edge. It changes them only in the busy scenario, which checks that they are ignored.

// File: rtl/sgd_pkg.sv
`timescale 1ns/1ps
package sgd_pkg;
  localparam int DESC_W  = 64;
  localparam int B_VALID = 0;
  localparam int B_END   = 1;
  localparam int B_IRQ   = 2;
  localparam int B_ACT1  = 4;
  localparam int B_ACT2  = 5;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 16;
  localparam int ADR_LSB = 32;
  localparam int ADR_W   = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_FIN} sgd_state_e;
  typedef enum logic [1:0] {REQ_EMPTY, REQ_OVER, REQ_WORK} req_kind_e;

  // Assemble one data-transfer descriptor word.
  function automatic logic [DESC_W-1:0] sgd_pack(input logic [ADR_W-1:0] adr,
                                                 input logic [LEN_W-1:0] len,
                                                 input logic             last);
    logic [DESC_W-1:0] d;
    d                       = '0;
    d[B_VALID]              = 1'b1;
    d[B_END]                = last;
    d[B_IRQ]                = 1'b0;
    d[B_ACT1]               = 1'b0;
    d[B_ACT2]               = 1'b1;
    d[LEN_LSB +: LEN_W]     = len;
    d[ADR_LSB +: ADR_W]     = adr;
    return d;
  endfunction
endpackage

// File: rtl/sgd_admit.sv
`timescale 1ns/1ps
// Classifies an incoming request: empty, too large for the table, or work.
module sgd_admit #(
  parameter int SIZE_W    = 32,
  parameter int MAX_CHUNK = 65532,
  parameter int TBL_DEPTH = 1024
) (
  input  logic [SIZE_W-1:0] bytes_i,
  output sgd_pkg::req_kind_e kind_o
);
  localparam logic [63:0] CAPACITY = 64'(TBL_DEPTH) * 64'(MAX_CHUNK);

  always_comb begin
    if (bytes_i == '0)                 kind_o = sgd_pkg::REQ_EMPTY;
    else if (64'(bytes_i) > CAPACITY)  kind_o = sgd_pkg::REQ_OVER;
    else                               kind_o = sgd_pkg::REQ_WORK;
  end
endmodule

// File: rtl/sgd_chunker.sv
`timescale 1ns/1ps
// Computes the next chunk length and whether it closes the request.
module sgd_chunker #(
  parameter int SIZE_W    = 32,
  parameter int MAX_CHUNK = 65532
) (
  input  logic [SIZE_W-1:0]        remain_i,
  output logic [sgd_pkg::LEN_W-1:0] len_o,
  output logic                     last_o
);
  localparam int          LW  = sgd_pkg::LEN_W;
  localparam logic [SIZE_W-1:0] CAP = SIZE_W'(MAX_CHUNK);

  always_comb begin
    last_o = (remain_i <= CAP);
    len_o  = last_o ? remain_i[LW-1:0] : LW'(MAX_CHUNK);
  end
endmodule

// File: rtl/sgd_emit.sv
`timescale 1ns/1ps
// Output register stage for the descriptor RAM write port.
module sgd_emit #(
  parameter int IDX_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [sgd_pkg::DESC_W-1:0] desc_i,
  output logic                       wr_en_o,
  output logic [IDX_W-1:0]           wr_idx_o,
  output logic [sgd_pkg::DESC_W-1:0] wr_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= load_i;
      if (load_i) begin
        wr_idx_o  <= idx_i;
        wr_data_o <= desc_i;
      end
    end
  end
endmodule

// File: rtl/sgd_table_builder.sv
`timescale 1ns/1ps
// Splits one transfer request into a table of scatter descriptors.
module sgd_table_builder #(
  parameter int          SIZE_W    = 32,
  parameter int          MAX_CHUNK = 65532,
  parameter int          TBL_DEPTH = 1024,
  parameter logic [31:0] TBL_BASE  = 32'h0000_4000,
  localparam int         IDX_W     = $clog2(TBL_DEPTH),
  localparam int         CNT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SIZE_W-1:0] req_bytes,
  input  logic [31:0]       req_base,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [63:0]       wr_data,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  entry_count,
  output logic [31:0]       tbl_base
);
  import sgd_pkg::*;

  sgd_state_e        state;
  req_kind_e         kind;
  logic [SIZE_W-1:0] remain;
  logic [31:0]       cursor;
  logic [CNT_W-1:0]  idx;
  logic              err_pend;
  logic [LEN_W-1:0]  chunk_len;
  logic              chunk_last;
  logic              accept;
  logic              fill;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign fill      = (state == ST_FILL);
  assign tbl_base  = TBL_BASE;

  sgd_admit #(
    .SIZE_W(SIZE_W), .MAX_CHUNK(MAX_CHUNK), .TBL_DEPTH(TBL_DEPTH)
  ) u_admit (
    .bytes_i(req_bytes),
    .kind_o (kind)
  );

  sgd_chunker #(
    .SIZE_W(SIZE_W), .MAX_CHUNK(MAX_CHUNK)
  ) u_chunk (
    .remain_i(remain),
    .len_o   (chunk_len),
    .last_o  (chunk_last)
  );

  sgd_emit #(
    .IDX_W(IDX_W)
  ) u_emit (
    .clk      (clk),
    .rst      (rst),
    .load_i   (fill),
    .idx_i    (idx[IDX_W-1:0]),
    .desc_i   (sgd_pack(cursor, chunk_len, chunk_last)),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      remain      <= '0;
      cursor      <= '0;
      idx         <= '0;
      err_pend    <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      entry_count <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            remain <= req_bytes;
            cursor <= req_base;
            idx    <= '0;
            if (kind == REQ_WORK) begin
              state <= ST_FILL;
            end else begin
              state    <= ST_FIN;
              err_pend <= (kind == REQ_OVER);
            end
          end
        end
        ST_FILL: begin
          remain <= remain - SIZE_W'(chunk_len);
          cursor <= cursor + 32'(chunk_len);
          idx    <= idx + 1'b1;
          if (chunk_last) state <= ST_FIN;
        end
        ST_FIN: begin
          done        <= 1'b1;
          err         <= err_pend;
          entry_count <= idx;
          err_pend    <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgd_table_builder_chk.sv
`timescale 1ns/1ps
// Protocol and format properties of the descriptor table builder.
module sgd_table_builder_chk #(
  parameter int MAX_CHUNK = 65532,
  parameter int TBL_DEPTH = 1024,
  parameter int IDX_W     = 10,
  parameter int CNT_W     = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [63:0]      wr_data,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] entry_count
);
  AST_DESC_ATTR: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[0] && !wr_data[2] && !wr_data[3] && !wr_data[4] &&
               wr_data[5] && wr_data[15:6] == '0));  // R2

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[31:16] != 16'd0 && 32'(wr_data[31:16]) <= 32'(MAX_CHUNK)));  // R3

  AST_ADDR_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_data[63:32] == $past(wr_data[63:32]) + 32'($past(wr_data[31:16])));  // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_idx == $past(wr_idx) + 1'b1);  // R4

  AST_NOT_END_CONT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[1]) |=> wr_en);  // R5

  AST_FULL_CHUNK_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[1]) |-> 32'(wr_data[31:16]) == 32'(MAX_CHUNK));  // R3

  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && entry_count == '0));  // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> 32'(entry_count) <= 32'(TBL_DEPTH));  // R6

  AST_END_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[1]) |=> (done && !wr_en));  // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);  // R9

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !req_ready);  // R9
endmodule

bind sgd_table_builder sgd_table_builder_chk #(
  .MAX_CHUNK(MAX_CHUNK), .TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .done       (done),
  .err        (err),
  .entry_count(entry_count)
);

// File: tb/sim_sgd_table_builder.sv
`timescale 1ns/1ps
module sim_sgd_table_builder;
  localparam int          CAP_LEN = 65532;
  localparam int          DEPTH   = 1024;
  localparam longint      LIMIT   = 64'd1024 * 64'd65532;
  localparam logic [31:0] BASE_P  = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_bytes = '0;
  logic [31:0] req_base = '0;
  logic        wr_en;
  logic [9:0]  wr_idx;
  logic [63:0] wr_data;
  logic        done;
  logic        err;
  logic [10:0] entry_count;
  logic [31:0] tbl_base;

  int n_chk = 0;
  int n_bad = 0;
  int nwr   = 0;
  logic [63:0] mem   [0:DEPTH-1];
  int          order [0:DEPTH-1];

  always #2.5 clk = ~clk;

  sgd_table_builder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bytes(req_bytes), .req_base(req_base), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done), .err(err), .entry_count(entry_count),
    .tbl_base(tbl_base)
  );

  // Write-port monitor: models the descriptor RAM, sampled mid-cycle.
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (nwr < DEPTH) order[nwr] = int'(wr_idx);
      mem[wr_idx] = wr_data;
      nwr = nwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(wr_en == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "strobes after reset",
        {wr_en, done, err}, 0);
    chk(entry_count == '0, "R1", "count after reset", entry_count, 0);
    chk(tbl_base == BASE_P, "R10", "table base", tbl_base, BASE_P);
  endtask

  // One request; hold keeps req_valid high with altered fields while busy.
  task automatic t_request(input longint bytes, input logic [31:0] base, input bit hold);
    int  n_exp;
    bit  over;
    int  lat;
    bit  ready_seen;
    int  bad;
    longint rem;
    logic [31:0] adr;
    logic [63:0] exp_d;
    logic [63:0] bad_act;
    logic [63:0] bad_exp;
    int  order_bad;
    int  cnt_at_done;

    over  = (bytes > LIMIT);
    n_exp = (over || bytes == 0) ? 0 : int'((bytes + CAP_LEN - 1) / CAP_LEN);
    nwr   = 0;

    @(negedge clk);
    req_valid = 1'b1;
    req_bytes = bytes[31:0];
    req_base  = base;
    @(posedge clk);
    @(negedge clk);
    if (hold) req_bytes = 32'd999; else req_valid = 1'b0;
    lat = 0;
    ready_seen = 1'b0;
    while (lat < 3000) begin
      if (req_ready && !done) ready_seen = 1'b1;
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
    end
    req_valid = 1'b0;

    chk(done == 1'b1 && lat == n_exp + 1, "R8", "done latency", lat, n_exp + 1);
    chk(err == over, over ? "R6" : "R7", "error flag", err, over);
    chk(int'(entry_count) == n_exp, "R8", "entry count", entry_count, n_exp);
    chk(nwr == n_exp, over ? "R6" : (bytes == 0 ? "R7" : "R4"), "writes made", nwr, n_exp);
    chk(!ready_seen, "R9", "ready low while busy", ready_seen, 0);

    order_bad = 0;
    for (int i = 0; i < n_exp && i < nwr; i++)
      if (order[i] != i) order_bad++;
    if (n_exp > 0) chk(order_bad == 0, "R4", "index order", order_bad, 0);

    bad = 0; bad_act = '0; bad_exp = '0;
    rem = bytes;
    adr = base;
    for (int i = 0; i < n_exp; i++) begin
      longint len;
      bit last;
      len  = (rem > CAP_LEN) ? CAP_LEN : rem;
      last = (rem == len);
      exp_d = {adr, len[15:0], 10'b0, 1'b1, 1'b0, 1'b0, 1'b0, last, 1'b1};
      if (mem[i] !== exp_d) begin
        if (bad == 0) begin bad_act = mem[i]; bad_exp = exp_d; end
        bad++;
      end
      adr = adr + len[31:0];
      rem = rem - len;
    end
    if (n_exp > 0)
      chk(bad == 0, "R2 R3 R5", "descriptor contents", bad_act, bad_exp);

    cnt_at_done = int'(entry_count);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(nwr == n_exp && req_ready == 1'b1, "R9", "no extra request started", nwr, n_exp);
    chk(int'(entry_count) == cnt_at_done, "R8", "count held", entry_count, cnt_at_done);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog R4: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();                                          // R1 R10
    t_request(512, 32'h1000_0000, 1'b0);                // R2 R3 R5
    t_request(0, 32'h0000_1234, 1'b0);                  // R7
    t_request(65532, 32'h2000_0000, 1'b0);              // R3 boundary
    t_request(65533, 32'h2000_0010, 1'b1);              // R3 R5 R9
    t_request(10 * 65532 + 100, 32'h8000_0002, 1'b0);   // R3 R4
    t_request(LIMIT + 1, 32'h3000_0000, 1'b0);          // R6
    t_request(LIMIT, 32'h4000_0000, 1'b1);              // R6 R4 R9
    chk(tbl_base == BASE_P, "R10", "table base at end", tbl_base, BASE_P);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule